// File: doc/BRIEF.md
# Postfix Stack Calculator

This block evaluates arithmetic written in postfix order on a small last-in, first-out register stack. Operands are pushed as 16-bit values. An add or subtract command names no operands: it consumes the two uppermost entries and leaves one result in their place. For example, the expression (2+3)-(6-3) is fed as `2 3 + 6 3 - -`. The current uppermost value and the stack depth are visible on plain output pins at all times. A pop command returns the uppermost value on a one-cycle result strobe.

Commands enter through a valid/ready handshake, and each accepted command completes in a single clock cycle. Back-pressure rule: `cmd_ready` is high while no error flag is latched. While an error flag is latched, `cmd_ready` is high only when the offered opcode is the clear command. The producer must hold `cmd_op` and `cmd_data` steady while `cmd_valid` is high and `cmd_ready` is low. The pop result output has no back-pressure: `out_valid` is high for exactly one cycle.

Pushing onto a full stack sets an overflow flag. Popping an empty stack, or an arithmetic command with fewer than two entries present, sets an underflow flag. In both cases nothing else changes. A flag stays latched until a clear command or reset.

Top module: `stack_calc`

## Requirements
- R1: After reset, `depth_count` is 0, `top_valid` is 0, both error flags are 0, `out_valid` is 0, and `cmd_ready` is 1.
- R2: An accepted push (opcode 0) places `cmd_data` on the stack. From the next cycle, `top_value` shows that value and `depth_count` is one higher.
- R3: An accepted pop (opcode 1) on a non-empty stack raises `out_valid` for exactly the next cycle, with `out_data` equal to the former top. Depth drops by one, and the entry beneath becomes the top, in strict last-in, first-out order.
- R4: An accepted add (opcode 2) with at least two entries replaces the two uppermost entries with their sum modulo 2^16. Depth drops by one.
- R5: An accepted subtract (opcode 3) with at least two entries replaces the two uppermost entries with (entry beneath top) minus (top), modulo 2^16. Depth drops by one.
- R6: A push when `depth_count` equals DEPTH (16 by default) sets `ovf_flag`. The stack contents and depth are left unchanged.
- R7: A pop on an empty stack, or an add or subtract with fewer than two entries, sets `udf_flag`. Stack contents and depth are unchanged, and `out_valid` stays low.
- R8: While either flag is set, `cmd_ready` is low for every opcode other than clear. No command changes the stack in that state.
- R9: A clear command (opcode 4) is accepted whether or not a flag is set. It drops both flags to 0 and leaves the stack contents and depth unchanged.
- R10: `top_valid` is 1 exactly when `depth_count` is nonzero. `top_value` reads 0 when the stack is empty.
- R11: Opcodes 5, 6 and 7 are accepted and have no effect on the stack, the flags or the result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 subtract, 4 clear, 5 to 7 no effect |
| cmd_data | input | 16 | Value for a push |
| top_value | output | 16 | Current uppermost entry, 0 when empty |
| top_valid | output | 1 | Stack is non-empty |
| depth_count | output | 5 | Number of entries held |
| out_valid | output | 1 | One-cycle strobe for a popped value |
| out_data | output | 16 | Popped value |
| ovf_flag | output | 1 | Latched overflow |
| udf_flag | output | 1 | Latched underflow |

## Verification
The bench drives a postfix expression and checks each intermediate top and depth. It also drives add and subtract results that wrap past 16 bits, where a design with a swapped subtract order or a widened sum would show the wrong top. It fills the stack exactly to DEPTH and pushes once more, which catches an off-by-one full test that either drops the value or corrupts an entry. It provokes underflow both with a pop on an empty stack and with an add on a single entry. It then offers a push while the flag is latched, to catch a design that keeps accepting commands. Finally it checks that clear releases the flag without disturbing the stack, and that a popped value comes out in last-in, first-out order after a full fill.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_CLEAR = 3'd4
  } calc_op_e;
endpackage

// File: rtl/stack_calc_regs.sv
module stack_calc_regs #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic          fold_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top_q,
  output logic [W-1:0]  second_q,
  output logic [CW-1:0] count_q
);
  logic [W-1:0] ent [DEPTH];

  // one writable slot per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_en && count_q == CW'(i))
        ent[i] <= wdata;
      else if (fold_en && count_q == CW'(i + 2))
        ent[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (push_en)
      count_q <= count_q + CW'(1);
    else if (pop_en || fold_en)
      count_q <= count_q - CW'(1);
  end

  always_comb begin
    top_q    = '0;
    second_q = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count_q == CW'(i + 1)) top_q    = ent[i];
      if (count_q == CW'(i + 2)) second_q = ent[i];
    end
  end

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> count_q == $past(count_q) + CW'(1));
  a_r6_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/stack_calc_alu.sv
module stack_calc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] below,
  input  logic [W-1:0] above,
  input  logic         minus,
  output logic [W-1:0] result
);
  // subtract order: entry beneath minus the top
  always_comb begin
    if (minus) result = below - above;
    else       result = below + above;
  end
endmodule

// File: rtl/stack_calc_ctrl.sv
module stack_calc_ctrl
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] count,
  input  logic          err_any,
  output logic          ready,
  output logic          push_en,
  output logic          pop_en,
  output logic          fold_en,
  output logic          minus,
  output logic          set_ovf,
  output logic          set_udf,
  output logic          clr_flags
);
  calc_op_e op;
  logic     take;
  logic     two_ok;

  assign op     = calc_op_e'(cmd_op);
  assign ready  = !err_any || (op == OP_CLEAR);
  assign take   = cmd_valid && ready;
  assign two_ok = count >= CW'(2);

  always_comb begin
    push_en   = 1'b0;
    pop_en    = 1'b0;
    fold_en   = 1'b0;
    set_ovf   = 1'b0;
    set_udf   = 1'b0;
    clr_flags = 1'b0;
    minus     = (op == OP_SUB);
    if (take) begin
      unique case (op)
        OP_PUSH: if (count == CW'(DEPTH)) set_ovf = 1'b1; else push_en = 1'b1;
        OP_POP:  if (count == '0) set_udf = 1'b1; else pop_en = 1'b1;
        OP_ADD,
        OP_SUB:  if (two_ok) fold_en = 1'b1; else set_udf = 1'b1;
        OP_CLEAR: clr_flags = 1'b1;
        default: ;
      endcase
    end
  end

  a_r8_no_update_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> !(push_en || pop_en || fold_en));
endmodule

// File: rtl/stack_calc.sv
module stack_calc
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic [W-1:0]  top_value,
  output logic          top_valid,
  output logic [CW-1:0] depth_count,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          ovf_flag,
  output logic          udf_flag
);
  logic         push_en, pop_en, fold_en, minus;
  logic         set_ovf, set_udf, clr_flags;
  logic [W-1:0] top_q, second_q, alu_res, wdata;

  stack_calc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .count(depth_count), .err_any(ovf_flag || udf_flag), .ready(cmd_ready),
    .push_en(push_en), .pop_en(pop_en), .fold_en(fold_en), .minus(minus),
    .set_ovf(set_ovf), .set_udf(set_udf), .clr_flags(clr_flags)
  );

  stack_calc_alu #(.W(W)) u_alu (
    .below(second_q), .above(top_q), .minus(minus), .result(alu_res)
  );

  assign wdata = push_en ? cmd_data : alu_res;

  stack_calc_regs #(.DEPTH(DEPTH), .W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
    .fold_en(fold_en), .wdata(wdata), .top_q(top_q), .second_q(second_q),
    .count_q(depth_count)
  );

  assign top_value = top_q;
  assign top_valid = depth_count != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      udf_flag  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop_en;
      if (pop_en) out_data <= top_q;
      if (clr_flags) begin
        ovf_flag <= 1'b0;
        udf_flag <= 1'b0;
      end else begin
        if (set_ovf) ovf_flag <= 1'b1;
        if (set_udf) udf_flag <= 1'b1;
      end
    end
  end

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> depth_count == $past(depth_count) - CW'(1));
  a_r8_frozen_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag || udf_flag) |=> $stable(depth_count));
  a_r7_underflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udf_flag) |-> $stable(depth_count) && !out_valid);
  a_r6_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> depth_count == CW'(DEPTH));
endmodule

// File: tb/stack_calc_tb.sv
`timescale 1ns/1ps
module stack_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'h0;
  logic [15:0] top_value, out_data;
  logic        top_valid, out_valid, ovf_flag, udf_flag;
  logic [4:0]  depth_count;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  stack_calc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .top_value(top_value),
    .top_valid(top_valid), .depth_count(depth_count), .out_valid(out_valid),
    .out_data(out_data), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  // {op, data, expected top, expected depth, expected out_valid, expected out_data}
  localparam int NV = 15;
  localparam logic [56:0] VEC [NV] = '{
    {3'd0, 16'h0002, 16'h0002, 5'd1, 1'b0, 16'h0000},
    {3'd0, 16'h0003, 16'h0003, 5'd2, 1'b0, 16'h0000},
    {3'd2, 16'h0000, 16'h0005, 5'd1, 1'b0, 16'h0000},
    {3'd0, 16'h0006, 16'h0006, 5'd2, 1'b0, 16'h0000},
    {3'd0, 16'h0003, 16'h0003, 5'd3, 1'b0, 16'h0000},
    {3'd3, 16'h0000, 16'h0003, 5'd2, 1'b0, 16'h0000},
    {3'd3, 16'h0000, 16'h0002, 5'd1, 1'b0, 16'h0000},
    {3'd1, 16'h0000, 16'h0000, 5'd0, 1'b1, 16'h0002},
    {3'd0, 16'h0001, 16'h0001, 5'd1, 1'b0, 16'h0000},
    {3'd0, 16'h0003, 16'h0003, 5'd2, 1'b0, 16'h0000},
    {3'd3, 16'h0000, 16'hFFFE, 5'd1, 1'b0, 16'h0000},
    {3'd0, 16'hFFFF, 16'hFFFF, 5'd2, 1'b0, 16'h0000},
    {3'd2, 16'h0000, 16'hFFFD, 5'd1, 1'b0, 16'h0000},
    {3'd5, 16'h1234, 16'hFFFD, 5'd1, 1'b0, 16'h0000},
    {3'd1, 16'h0000, 16'h0000, 5'd0, 1'b1, 16'hFFFD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offer a command for one cycle; returns at the following falling edge
  task automatic cmd(input logic [2:0] op, input logic [15:0] d);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    chk("R1 depth", 32'(depth_count), 0);
    chk("R1 flags", {30'd0, ovf_flag, udf_flag}, 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R10 top_valid empty", 32'(top_valid), 0);
    chk("R10 top_value empty", 32'(top_value), 0);

    // table walk: R2 R3 R4 R5 R11
    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][56:54], VEC[i][53:38]);
      chk("R2-R5/R11 table top", 32'(top_value), 32'(VEC[i][37:22]));
      chk("R2-R5/R11 table depth", 32'(depth_count), 32'(VEC[i][21:17]));
      chk("R3 table out_valid", 32'(out_valid), 32'(VEC[i][16]));
      if (VEC[i][16]) chk("R3 table out_data", 32'(out_data), 32'(VEC[i][15:0]));
      chk("R11 table flags", {30'd0, ovf_flag, udf_flag}, 0);
      chk("R10 table top_valid", 32'(top_valid), 32'(VEC[i][21:17] != 0));
    end
    @(negedge clk);
    chk("R3 out_valid single cycle", 32'(out_valid), 0);

    // R7 pop on empty
    cmd(3'd1, 16'h0);
    chk("R7 udf on empty pop", 32'(udf_flag), 1);
    chk("R7 no out on empty pop", 32'(out_valid), 0);
    chk("R7 depth kept", 32'(depth_count), 0);
    // R8 push refused while flag latched
    cmd_op = 3'd0;
    #0.1;
    chk("R8 ready low", 32'(cmd_ready), 0);
    cmd(3'd0, 16'h00AA);
    chk("R8 push ignored", 32'(depth_count), 0);
    cmd_op = 3'd4;
    #0.1;
    chk("R9 ready for clear", 32'(cmd_ready), 1);
    cmd(3'd4, 16'h0);
    chk("R9 flag cleared", 32'(udf_flag), 0);

    // R7 add with one entry
    cmd(3'd0, 16'h0007);
    cmd(3'd2, 16'h0);
    chk("R7 udf on short add", 32'(udf_flag), 1);
    chk("R7 top kept", 32'(top_value), 32'h7);
    chk("R7 depth kept short add", 32'(depth_count), 1);
    cmd(3'd4, 16'h0);
    chk("R9 stack kept top", 32'(top_value), 32'h7);
    chk("R9 stack kept depth", 32'(depth_count), 1);

    // R6 fill to DEPTH then overflow
    for (int k = 1; k < 16; k++) cmd(3'd0, 16'(16'h0100 + k));
    chk("R6 full depth", 32'(depth_count), 16);
    chk("R6 no flag at full", 32'(ovf_flag), 0);
    cmd(3'd0, 16'hBEEF);
    chk("R6 ovf set", 32'(ovf_flag), 1);
    chk("R6 depth kept", 32'(depth_count), 16);
    chk("R6 top kept", 32'(top_value), 32'h010F);
    cmd(3'd4, 16'h0);
    cmd(3'd1, 16'h0);
    chk("R3 lifo pop", 32'(out_data), 32'h010F);
    chk("R3 next top", 32'(top_value), 32'h010E);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 depth after reset", 32'(depth_count), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule